// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Control

This combinational unit sits beside the register-read and execute stages of a five-stage in-order load/store pipeline (fetch, decode, execute, memory, write-back). For each of the two operands of the instruction now in execute, it compares the source register number with the destination of the instruction one stage ahead (execute/memory register) and two stages ahead (memory/write-back register). From that comparison it drives a 2-bit select code for that operand's ALU input mux. The select chooses among the register-file value, the ALU result held one stage ahead and the write-back value held two stages ahead.

The unit also finds the one dependency that forwarding cannot cover: a load in execute whose result a decode-stage instruction needs at once. When this happens it freezes the program counter and the fetch/decode register for one cycle. It also steers the control mux in front of execute to all-zero control, so a bubble enters the pipe instead of the decoded control. Once the bubble reaches execute, the execute instruction is no longer a load, the stall ends, and the load's result is forwarded from the memory/write-back register. Register 31 reads as zero, so it never takes part in forwarding or stalling. The unit holds no state of its own.

Top module: `hz_ctrl_unit`

## Requirements
- R1: Each operand select is one of three codes: 2'b00 takes the register-file value, 2'b10 takes the ALU result of the instruction one stage ahead, and 2'b01 takes the write-back value of the instruction two stages ahead. Code 2'b11 never appears.
- R2: When `alu_wen` is 1, `alu_dst` is not 31 and `alu_dst` equals an execute source, that operand's select is 2'b10.
- R3: When the one-stage-ahead match of R2 does not hold, and `wb_wen` is 1, `wb_dst` is not 31 and `wb_dst` equals the source, the select is 2'b01.
- R4: When both the one-ahead and the two-ahead instruction write the same source register, the select is 2'b10, so the newer value wins.
- R5: A destination of register 31 never causes forwarding, whatever the write flags are.
- R6: A destination match whose write flag is 0 has no effect on the select.
- R7: The second operand (`fwd_b`, the store data or second ALU input) follows the same rules as the first, independently of it.
- R8: With no load-use hazard, `pc_wen` = 1, `ifid_wen` = 1 and `bubble_sel` = 0.
- R9: When `ex_is_load` is 1 and `ex_dst` (not 31) equals `id_src_a` or `id_src_b`, the outputs are `pc_wen` = 0, `ifid_wen` = 0 and `bubble_sel` = 1. Once the bubble occupies execute (`ex_is_load` = 0), these return to the values of R8, so the stall lasts one cycle.
- R10: No stall occurs for a load into register 31, for a non-load in execute whose destination matches, or for a load whose destination matches neither decode source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | 5 | First source register of the decode-stage instruction |
| id_src_b | input | 5 | Second source register of the decode-stage instruction |
| ex_src_a | input | 5 | First source register of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register of the execute-stage instruction |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| ex_is_load | input | 1 | Execute-stage instruction reads data memory |
| alu_dst | input | 5 | Destination held in the execute/memory register |
| alu_wen | input | 1 | Register-write flag held in the execute/memory register |
| wb_dst | input | 5 | Destination held in the memory/write-back register |
| wb_wen | input | 1 | Register-write flag held in the memory/write-back register |
| fwd_a | output | 2 | Select code for the first ALU operand mux |
| fwd_b | output | 2 | Select code for the second ALU operand mux |
| pc_wen | output | 1 | Program counter write enable |
| ifid_wen | output | 1 | Fetch/decode pipeline register write enable |
| bubble_sel | output | 1 | 1 steers all-zero control into execute |

## Verification
The stimulus mimics pipeline timing. There is a back-to-back dependency that only the one-ahead path can satisfy, a distance-two dependency that only the write-back path can satisfy, and a case where both stages write the same register, which shows whether the priority is right. Register 31 destinations and cleared write flags check that a bare number match is not enough to forward. Mixed patterns, where each operand needs a different source, catch swapped or shared select logic. A load-use sequence checks the stall first on the first and then on the second decode source. It then moves the load one stage ahead and checks that the stall clears and the load result is forwarded. Near-miss cases (a load into register 31, a matching non-load, a load with no matching source) show that the stall depends on every one of its conditions.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        OPND_REGFILE  = 2'b00,
        OPND_FROM_WB  = 2'b01,
        OPND_FROM_ALU = 2'b10
    } opnd_sel_e;

    typedef struct packed {
        logic pc_wen;
        logic ifid_wen;
        logic bubble_sel;
    } stall_ctl_t;

    localparam stall_ctl_t STALL_RUN    = '{pc_wen: 1'b1, ifid_wen: 1'b1, bubble_sel: 1'b0};
    localparam stall_ctl_t STALL_BUBBLE = '{pc_wen: 1'b0, ifid_wen: 1'b0, bubble_sel: 1'b1};

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int AW       = 5,
    parameter int ZERO_REG = 31
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          wen,
    output logic          hit
);
    localparam logic [AW-1:0] ZR = AW'(ZERO_REG);

    always_comb begin
        hit = wen && (dst != ZR) && (dst == src);
    end
endmodule

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
    import hz_pkg::*;
#(
    parameter int AW       = 5,
    parameter int ZERO_REG = 31
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] alu_dst,
    input  logic          alu_wen,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wen,
    output opnd_sel_e     sel
);
    logic hit_alu;
    logic hit_wb;

    hz_src_match #(.AW(AW), .ZERO_REG(ZERO_REG)) u_m_alu (
        .src (src),
        .dst (alu_dst),
        .wen (alu_wen),
        .hit (hit_alu)
    );

    hz_src_match #(.AW(AW), .ZERO_REG(ZERO_REG)) u_m_wb (
        .src (src),
        .dst (wb_dst),
        .wen (wb_wen),
        .hit (hit_wb)
    );

    // Newer producer (one stage ahead) wins over the older one.
    always_comb begin
        unique case ({hit_alu, hit_wb})
            2'b10, 2'b11: sel = OPND_FROM_ALU;
            2'b01:        sel = OPND_FROM_WB;
            default:      sel = OPND_REGFILE;
        endcase
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hz_pkg::*;
#(
    parameter int AW       = 5,
    parameter int ZERO_REG = 31,
    parameter int NUM_SRC  = 2
) (
    input  logic [NUM_SRC-1:0][AW-1:0] id_srcs,
    input  logic [AW-1:0]              ex_dst,
    input  logic                       ex_is_load,
    output stall_ctl_t                 ctl
);
    logic [NUM_SRC-1:0] src_hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        hz_src_match #(.AW(AW), .ZERO_REG(ZERO_REG)) u_m (
            .src (id_srcs[i]),
            .dst (ex_dst),
            .wen (ex_is_load),
            .hit (src_hit[i])
        );
    end

    always_comb begin
        ctl = (|src_hit) ? STALL_BUBBLE : STALL_RUN;
    end
endmodule

// File: rtl/hz_ctrl_unit.sv
module hz_ctrl_unit
    import hz_pkg::*;
#(
    parameter int AW       = 5,
    parameter int ZERO_REG = 31
) (
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_is_load,
    input  logic [AW-1:0] alu_dst,
    input  logic          alu_wen,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wen,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          pc_wen,
    output logic          ifid_wen,
    output logic          bubble_sel
);
    localparam int NUM_OPND = 2;

    logic [NUM_OPND-1:0][AW-1:0] ex_srcs;
    logic [NUM_OPND-1:0][AW-1:0] id_srcs;
    opnd_sel_e                   sel [NUM_OPND];
    stall_ctl_t                  stall;

    assign ex_srcs = {ex_src_b, ex_src_a};
    assign id_srcs = {id_src_b, id_src_a};

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
        hz_opnd_sel #(.AW(AW), .ZERO_REG(ZERO_REG)) u_sel (
            .src     (ex_srcs[k]),
            .alu_dst (alu_dst),
            .alu_wen (alu_wen),
            .wb_dst  (wb_dst),
            .wb_wen  (wb_wen),
            .sel     (sel[k])
        );
    end

    hz_load_use #(.AW(AW), .ZERO_REG(ZERO_REG), .NUM_SRC(NUM_OPND)) u_lu (
        .id_srcs    (id_srcs),
        .ex_dst     (ex_dst),
        .ex_is_load (ex_is_load),
        .ctl        (stall)
    );

    always_comb begin
        fwd_a      = sel[0];
        fwd_b      = sel[1];
        pc_wen     = stall.pc_wen;
        ifid_wen   = stall.ifid_wen;
        bubble_sel = stall.bubble_sel;
    end
endmodule

// File: rtl/hz_ctrl_checker.sv
module hz_ctrl_checker #(
    parameter int AW       = 5,
    parameter int ZERO_REG = 31
) (
    input logic [AW-1:0] id_src_a,
    input logic [AW-1:0] id_src_b,
    input logic [AW-1:0] ex_src_a,
    input logic [AW-1:0] ex_src_b,
    input logic [AW-1:0] ex_dst,
    input logic          ex_is_load,
    input logic [AW-1:0] alu_dst,
    input logic          alu_wen,
    input logic [AW-1:0] wb_dst,
    input logic          wb_wen,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic          pc_wen,
    input logic          ifid_wen,
    input logic          bubble_sel
);
    localparam logic [AW-1:0] ZR = AW'(ZERO_REG);

    always_comb begin
        p_legal_code_r1: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
        p_alu_path_r4: assert (!(alu_wen && alu_dst != ZR && alu_dst == ex_src_a) || fwd_a == 2'b10);
        p_opnd_b_alu_r7: assert (!(alu_wen && alu_dst != ZR && alu_dst == ex_src_b) || fwd_b == 2'b10);
        p_wb_path_r3: assert (!(wb_wen && wb_dst != ZR && wb_dst == ex_src_a &&
                                !(alu_wen && alu_dst == ex_src_a)) || fwd_a == 2'b01);
        p_no_writers_r6: assert ((alu_wen || wb_wen) || (fwd_a == 2'b00 && fwd_b == 2'b00));
        p_zero_dst_r5: assert (!(alu_dst == ZR && wb_dst == ZR) || (fwd_a == 2'b00 && fwd_b == 2'b00));
        p_stall_coherent_r8: assert (pc_wen == ifid_wen && bubble_sel == !pc_wen);
        p_no_load_run_r10: assert (ex_is_load || pc_wen);
        p_load_use_r9: assert (!(ex_is_load && ex_dst != ZR &&
                                 (ex_dst == id_src_a || ex_dst == id_src_b)) || bubble_sel);
    end
endmodule

bind hz_ctrl_unit hz_ctrl_checker #(.AW(AW), .ZERO_REG(ZERO_REG)) u_chk (.*);

// File: tb/sim_hz_ctrl_unit.sv
module sim_hz_ctrl_unit;

    typedef struct {
        logic [1:0] fa;
        logic [1:0] fb;
        logic       stall;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [4:0] id_src_a = '0, id_src_b = '0, ex_src_a = '0, ex_src_b = '0;
    logic [4:0] ex_dst = '0, alu_dst = '0, wb_dst = '0;
    logic       ex_is_load = 1'b0, alu_wen = 1'b0, wb_wen = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic       pc_wen, ifid_wen, bubble_sel;

    hz_ctrl_unit u0 (
        .id_src_a (id_src_a), .id_src_b (id_src_b),
        .ex_src_a (ex_src_a), .ex_src_b (ex_src_b),
        .ex_dst (ex_dst), .ex_is_load (ex_is_load),
        .alu_dst (alu_dst), .alu_wen (alu_wen),
        .wb_dst (wb_dst), .wb_wen (wb_wen),
        .fwd_a (fwd_a), .fwd_b (fwd_b),
        .pc_wen (pc_wen), .ifid_wen (ifid_wen), .bubble_sel (bubble_sel)
    );

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    task automatic drive(input logic [4:0] ia, input logic [4:0] ib,
                         input logic [4:0] ea, input logic [4:0] eb,
                         input logic [4:0] ed, input logic ld,
                         input logic [4:0] ad, input logic aw,
                         input logic [4:0] wd, input logic ww,
                         input logic [1:0] efa, input logic [1:0] efb,
                         input logic estall, input string tag);
        exp_t e;
        @(posedge clk);
        id_src_a = ia; id_src_b = ib; ex_src_a = ea; ex_src_b = eb;
        ex_dst = ed; ex_is_load = ld; alu_dst = ad; alu_wen = aw;
        wb_dst = wd; wb_wen = ww;
        e.fa = efa; e.fb = efb; e.stall = estall; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: samples on the falling edge, half a period after inputs change.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "fwd_a", fwd_a, e.fa);
                cmp(e.tag, "fwd_b", fwd_b, e.fb);
                cmp(e.tag, "pc_wen", pc_wen, !e.stall);
                cmp(e.tag, "ifid_wen", ifid_wen, !e.stall);
                cmp(e.tag, "bubble_sel", bubble_sel, e.stall);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        //     ida ib  ea  eb  exd ld  ad  aw  wd  ww  fa     fb     stall
        drive(0,  0,  0,  0,  0,  0,  0,  0,  0,  0,  2'b00, 2'b00, 0, "R8 idle after reset");
        drive(0,  0,  5,  1,  0,  0,  5,  1,  0,  0,  2'b10, 2'b00, 0, "R1 R2 back-to-back");
        drive(0,  0,  3,  1,  0,  0,  0,  0,  3,  1,  2'b01, 2'b00, 0, "R1 R3 distance two");
        drive(0,  0,  7,  1,  0,  0,  7,  1,  7,  1,  2'b10, 2'b00, 0, "R4 both stages match");
        drive(0,  0, 31, 31,  0,  0, 31,  1, 31,  1,  2'b00, 2'b00, 0, "R5 zero register");
        drive(0,  0,  9,  1,  0,  0,  9,  0,  9,  0,  2'b00, 2'b00, 0, "R6 write flags low");
        drive(0,  0,  9,  1,  0,  0,  9,  0,  9,  1,  2'b01, 2'b00, 0, "R6 only wb writes");
        drive(0,  0,  1,  4,  0,  0,  4,  1,  0,  0,  2'b00, 2'b10, 0, "R7 store data ahead");
        drive(0,  0,  2,  6,  0,  0,  2,  1,  6,  1,  2'b10, 2'b01, 0, "R7 mixed operands");
        drive(8,  2,  0,  0,  8,  1,  0,  0,  0,  0,  2'b00, 2'b00, 1, "R9 load-use src a");
        drive(1,  8,  0,  0,  8,  1,  0,  0,  0,  0,  2'b00, 2'b00, 1, "R9 load-use src b");
        drive(1,  8,  0,  0,  0,  0,  8,  1,  0,  0,  2'b00, 2'b00, 0, "R9 bubble in EX releases");
        drive(3,  8,  1,  8,  3,  0,  0,  0,  8,  1,  2'b00, 2'b01, 0, "R9 load value forwarded");
        drive(31, 0,  0,  0, 31,  1,  0,  0,  0,  0,  2'b00, 2'b00, 0, "R10 load to zero reg");
        drive(8,  0,  0,  0,  8,  0,  0,  0,  0,  0,  2'b00, 2'b00, 0, "R10 non-load match");
        drive(3,  4,  0,  0,  8,  1,  0,  0,  0,  0,  2'b00, 2'b00, 0, "R10 load no match");
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule